// File: doc/BRIEF.md
# UART Host Register Front End

This block is the byte-wide register file that a host processor sees in a classic eight-offset serial port. It decodes a 3-bit offset with separate read and write strobes. The decode depends on the direction of the access and on the divisor-access bit held in line control. The block stores the divisor, line control, modem control, scratch and interrupt-enable values. It keeps the line status flags and owns two small byte queues: one toward the transmitter and one from the receiver.

On the device side, bytes leave through a valid/ready transmit port and arrive through a valid/ready receive port. A loopback mode routes host transmit writes straight into the receive queue. The block does not rank interrupts. It exports the enable bits, the line status and a one-cycle pulse when the transmit queue drains. A companion block ranks these and returns the identification byte, which is shown at offset 2. Bit timing, baud generation, parity and queue-control writes are handled elsewhere.

Read data is combinational while `host_rd` is high. Read side effects (queue pop, overrun clear) take place at the clock edge that ends the access.

Top module: `uart_regfile`

## Requirements
- R1: When line control bit 7 is set, offset 0 reads and writes the divisor low byte and offset 1 the divisor high byte; `divisor` outputs {high, low}.
- R2: When line control bit 7 is clear, offset 1 reads and writes the interrupt enable value, which keeps only bits 3:0 (upper bits read 0) and drives `irq_enable`.
- R3: Offset 2 reads `iir_in`, and a write to it changes nothing; writes to offsets 5 and 6 change nothing; offset 6 reads 0.
- R4: Offset 3 (line control) stores all 8 bits, offset 4 (modem control) keeps bits 4:0 with upper bits read 0, offset 7 (scratch) stores 8 bits.
- R5: After reset, interrupt enable, line control, modem control, scratch and divisor read 0, line status reads 0x60, and `tx_valid` and `thre_event` are low.
- R6: With loopback off, an offset-0 write (bit 7 clear) appends the byte to the transmit queue if it has room, and drops it otherwise; either way, line status bits 5 and 6 go to 0.
- R7: `tx_valid` is high while the transmit queue holds a byte, `tx_data` shows the oldest byte, and it is removed when `tx_ready` is high; it is held stable otherwise.
- R8: When the last transmit byte is taken and no offset-0 data write happens in that cycle, line status bits 5 and 6 are set and `thre_event` is high for exactly the next cycle.
- R9: Modem control bit 4 selects loopback. In loopback an offset-0 data write goes into the receive queue, or sets overrun (line status bit 1) if that queue is full, and sets bits 5 and 6. While loopback is on, `rx_ready` is low and `rx_valid` is ignored.
- R10: With loopback off, `rx_ready` is high when the receive queue has room; an `rx_valid` byte is then appended, while an `rx_valid` against a full queue is refused and sets overrun.
- R11: Line status bit 0 is high while the receive queue is non-empty; an offset-0 read with bit 7 clear returns the oldest byte and removes it, or returns 0 when the queue is empty.
- R12: An offset-5 read returns line status and then clears overrun, except when overrun is set again in the same cycle; the upper bit and bits 4:2 read 0.
- R13: Both queues hold 16 bytes by default and keep arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | 3 | Register offset |
| host_rd | input | 1 | Read strobe, side effects at the clock edge |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid while host_rd is high, else 0 |
| iir_in | input | 8 | Identification byte from the interrupt ranking block |
| tx_data | output | 8 | Oldest transmit byte |
| tx_valid | output | 1 | Transmit queue non-empty |
| tx_ready | input | 1 | Device takes tx_data |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte offered |
| rx_ready | output | 1 | Receive queue accepts a byte |
| irq_enable | output | 4 | Interrupt enable bits |
| line_status | output | 8 | Current line status byte |
| thre_event | output | 1 | One-cycle pulse after the transmit queue drains |
| divisor | output | 16 | Divisor latch {high, low} |

## Verification
The assertions that tie line status bit 5 to a non-empty transmit queue assume queue depths of two or more, which the default parameters keep. The overrun-clear property only looks at line status reads with no write and no `rx_valid` in the same cycle, so it does not depend on how the device times its receive offers. The bench never raises both host strobes together. It offers `rx_valid` regardless of `rx_ready`, so refused pushes and overruns do happen. It varies `tx_ready` duty between phases, so both full-queue drops and drain events occur.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;

    localparam int DLAB_BIT  = 7;
    localparam int LOOP_BIT  = 4;

    typedef enum logic [3:0] {
        RSEL_NONE,
        RSEL_RXBUF,
        RSEL_DLL,
        RSEL_DLH,
        RSEL_IER,
        RSEL_IIR,
        RSEL_LCR,
        RSEL_MCR,
        RSEL_LSR,
        RSEL_MSR,
        RSEL_SCR
    } rsel_e;

    typedef struct packed {
        logic thr;
        logic ier;
        logic dll;
        logic dlh;
        logic lcr;
        logic mcr;
        logic scr;
    } wsel_t;

    typedef struct packed {
        logic [3:0] ier;
        logic [7:0] lcr;
        logic [4:0] mcr;
        logic [7:0] scr;
        logic [7:0] dll;
        logic [7:0] dlh;
        logic       oe;
        logic       thre;
        logic       thre_ev;
    } regs_t;

endpackage

// File: rtl/uart_addr_decode.sv
module uart_addr_decode
    import uart_regs_pkg::*;
(
    input  logic [2:0] addr,
    input  logic       dlab,
    input  logic       wr,
    output rsel_e      rsel,
    output wsel_t      wsel
);

    always_comb begin
        rsel = RSEL_NONE;
        wsel = '0;
        case (addr)
            3'd0: begin
                rsel     = dlab ? RSEL_DLL : RSEL_RXBUF;
                wsel.dll = wr & dlab;
                wsel.thr = wr & ~dlab;
            end
            3'd1: begin
                rsel     = dlab ? RSEL_DLH : RSEL_IER;
                wsel.dlh = wr & dlab;
                wsel.ier = wr & ~dlab;
            end
            3'd2: rsel = RSEL_IIR;
            3'd3: begin
                rsel     = RSEL_LCR;
                wsel.lcr = wr;
            end
            3'd4: begin
                rsel     = RSEL_MCR;
                wsel.mcr = wr;
            end
            3'd5: rsel = RSEL_LSR;
            3'd6: rsel = RSEL_MSR;
            default: begin
                rsel     = RSEL_SCR;
                wsel.scr = wr;
            end
        endcase
    end

endmodule

// File: rtl/uart_byte_queue.sv
module uart_byte_queue #(
    parameter  int DEPTH = 16,
    parameter  int W     = 8,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          empty
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [AW-1:0] rd;
        logic [AW-1:0] wr;
        logic [CW-1:0] cnt;
    } qptr_t;

    qptr_t         p_d, p_q;
    logic [W-1:0]  mem_q [DEPTH];
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        p_d     = p_q;
        do_push = push && (p_q.cnt != CW'(DEPTH));
        do_pop  = pop && (p_q.cnt != '0);
        if (do_push) p_d.wr = step(p_q.wr);
        if (do_pop)  p_d.rd = step(p_q.rd);
        case ({do_push, do_pop})
            2'b10:   p_d.cnt = p_q.cnt + 1'b1;
            2'b01:   p_d.cnt = p_q.cnt - 1'b1;
            default: p_d.cnt = p_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[p_q.wr] <= din;
    end

    assign dout  = mem_q[p_q.rd];
    assign count = p_q.cnt;
    assign empty = (p_q.cnt == '0);

endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
    import uart_regs_pkg::*;
#(
    parameter int RX_DEPTH = 16,
    parameter int TX_DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  host_addr,
    input  logic        host_rd,
    input  logic        host_wr,
    input  logic [7:0]  host_wdata,
    output logic [7:0]  host_rdata,
    input  logic [7:0]  iir_in,
    output logic [7:0]  tx_data,
    output logic        tx_valid,
    input  logic        tx_ready,
    input  logic [7:0]  rx_data,
    input  logic        rx_valid,
    output logic        rx_ready,
    output logic [3:0]  irq_enable,
    output logic [7:0]  line_status,
    output logic        thre_event,
    output logic [15:0] divisor
);

    localparam int RX_CW = $clog2(RX_DEPTH + 1);
    localparam int TX_CW = $clog2(TX_DEPTH + 1);

    regs_t            regs_d, regs_q;
    rsel_e            rsel;
    wsel_t            wsel;
    logic             dlab, loop_mode;
    logic [RX_CW-1:0] rx_count;
    logic [TX_CW-1:0] tx_count;
    logic             rx_empty, tx_empty, rx_full, tx_full;
    logic [7:0]       rx_dout, rx_din;
    logic             rd_rx, rd_lsr;
    logic             tx_push, tx_pop, tx_last;
    logic             lb_req, dv_req, rx_push, rx_pop, oe_set;
    logic [7:0]       rd_val;

    assign dlab      = regs_q.lcr[DLAB_BIT];
    assign loop_mode = regs_q.mcr[LOOP_BIT];

    uart_addr_decode dec_i (
        .addr (host_addr),
        .dlab (dlab),
        .wr   (host_wr),
        .rsel (rsel),
        .wsel (wsel)
    );

    uart_byte_queue #(.DEPTH(RX_DEPTH), .W(8)) rxq_i (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rx_push),
        .din   (rx_din),
        .pop   (rx_pop),
        .dout  (rx_dout),
        .count (rx_count),
        .empty (rx_empty)
    );

    uart_byte_queue #(.DEPTH(TX_DEPTH), .W(8)) txq_i (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (tx_push),
        .din   (host_wdata),
        .pop   (tx_pop),
        .dout  (tx_data),
        .count (tx_count),
        .empty (tx_empty)
    );

    // queue control, all decided from the state before the edge
    always_comb begin
        rx_full  = (rx_count == RX_CW'(RX_DEPTH));
        tx_full  = (tx_count == TX_CW'(TX_DEPTH));
        rd_rx    = host_rd && (rsel == RSEL_RXBUF);
        rd_lsr   = host_rd && (rsel == RSEL_LSR);
        tx_valid = !tx_empty;
        tx_pop   = tx_valid && tx_ready;
        tx_push  = wsel.thr && !loop_mode && !tx_full;
        tx_last  = tx_pop && (tx_count == TX_CW'(1)) && !wsel.thr;
        lb_req   = wsel.thr && loop_mode;
        dv_req   = rx_valid && !loop_mode;
        rx_push  = (lb_req || dv_req) && !rx_full;
        rx_din   = loop_mode ? host_wdata : rx_data;
        oe_set   = (lb_req || dv_req) && rx_full;
        rx_pop   = rd_rx && !rx_empty;
        rx_ready = !loop_mode && !rx_full;
    end

    // next register state
    always_comb begin
        regs_d = regs_q;
        if (wsel.ier) regs_d.ier = host_wdata[3:0];
        if (wsel.lcr) regs_d.lcr = host_wdata;
        if (wsel.mcr) regs_d.mcr = host_wdata[4:0];
        if (wsel.scr) regs_d.scr = host_wdata;
        if (wsel.dll) regs_d.dll = host_wdata;
        if (wsel.dlh) regs_d.dlh = host_wdata;
        if (rd_lsr)   regs_d.oe  = 1'b0;
        if (oe_set)   regs_d.oe  = 1'b1;
        if (wsel.thr)     regs_d.thre = loop_mode;
        else if (tx_last) regs_d.thre = 1'b1;
        regs_d.thre_ev = tx_last;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q      <= '0;
            regs_q.thre <= 1'b1;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign line_status = {1'b0, regs_q.thre, regs_q.thre, 3'b000, regs_q.oe, !rx_empty};
    assign irq_enable  = regs_q.ier;
    assign thre_event  = regs_q.thre_ev;
    assign divisor     = {regs_q.dlh, regs_q.dll};

    always_comb begin
        case (rsel)
            RSEL_RXBUF: rd_val = rx_empty ? 8'h00 : rx_dout;
            RSEL_DLL:   rd_val = regs_q.dll;
            RSEL_DLH:   rd_val = regs_q.dlh;
            RSEL_IER:   rd_val = {4'h0, regs_q.ier};
            RSEL_IIR:   rd_val = iir_in;
            RSEL_LCR:   rd_val = regs_q.lcr;
            RSEL_MCR:   rd_val = {3'b000, regs_q.mcr};
            RSEL_LSR:   rd_val = line_status;
            RSEL_SCR:   rd_val = regs_q.scr;
            default:    rd_val = 8'h00;
        endcase
        host_rdata = host_rd ? rd_val : 8'h00;
    end

endmodule

// File: rtl/uart_regfile_chk.sv
module uart_regfile_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  host_addr,
    input logic        host_rd,
    input logic        host_wr,
    input logic        rx_valid,
    input logic        rx_ready,
    input logic        tx_valid,
    input logic        tx_ready,
    input logic [7:0]  tx_data,
    input logic [7:0]  line_status,
    input logic [3:0]  irq_enable,
    input logic [15:0] divisor,
    input logic        thre_event,
    input logic        loop_mode
);

    AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !host_wr |=> $stable(divisor)); // R1

    AST_IER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !host_wr |=> $stable(irq_enable)); // R2

    AST_THRE_MEANS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        !line_status[5] |-> tx_valid); // R6

    AST_TX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R7

    AST_DRAIN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        thre_event |-> (line_status[5] && line_status[6] && !tx_valid)); // R8

    AST_LOOP_BLOCKS_RX: assert property (@(posedge clk) disable iff (!rst_n)
        loop_mode |-> !rx_ready); // R9

    AST_RX_ACCEPT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready) |=> line_status[0]); // R10

    AST_OE_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == 3'd5 && !host_wr && !rx_valid) |=> !line_status[1]); // R12

endmodule

bind uart_regfile uart_regfile_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_addr   (host_addr),
    .host_rd     (host_rd),
    .host_wr     (host_wr),
    .rx_valid    (rx_valid),
    .rx_ready    (rx_ready),
    .tx_valid    (tx_valid),
    .tx_ready    (tx_ready),
    .tx_data     (tx_data),
    .line_status (line_status),
    .irq_enable  (irq_enable),
    .divisor     (divisor),
    .thre_event  (thre_event),
    .loop_mode   (loop_mode)
);

// File: tb/uart_regfile_tb_top.sv
module uart_regfile_tb_top;

    localparam int PERIOD = 10;
    localparam int DEPTH  = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  host_addr = '0;
    logic        host_rd = 1'b0;
    logic        host_wr = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic [7:0]  iir_in = '0;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic [3:0]  irq_enable;
    logic [7:0]  line_status;
    logic        thre_event;
    logic [15:0] divisor;

    int nchk = 0;
    int nerr = 0;

    // reference model state
    logic [3:0] m_ier = '0;
    logic [7:0] m_lcr = '0, m_scr = '0, m_dll = '0, m_dlh = '0;
    logic [4:0] m_mcr = '0;
    logic       m_oe = 1'b0, m_thre = 1'b1, m_ev = 1'b0;
    logic [7:0] m_rxq[$];
    logic [7:0] m_txq[$];

    always #(PERIOD/2) clk = ~clk;

    uart_regfile #(.RX_DEPTH(DEPTH), .TX_DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .host_addr(host_addr), .host_rd(host_rd), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .iir_in(iir_in),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .irq_enable(irq_enable), .line_status(line_status),
        .thre_event(thre_event), .divisor(divisor)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_lsr();
        return {1'b0, m_thre, m_thre, 3'b000, m_oe, (m_rxq.size() != 0)};
    endfunction

    function automatic logic [7:0] exp_read(input logic [2:0] a, input logic [7:0] iir);
        logic d = m_lcr[7];
        case (a)
            3'd0: return d ? m_dll : ((m_rxq.size() != 0) ? m_rxq[0] : 8'h00);
            3'd1: return d ? m_dlh : {4'h0, m_ier};
            3'd2: return iir;
            3'd3: return m_lcr;
            3'd4: return {3'b000, m_mcr};
            3'd5: return exp_lsr();
            3'd6: return 8'h00;
            default: return m_scr;
        endcase
    endfunction

    function automatic string read_tag(input logic [2:0] a);
        logic d = m_lcr[7];
        case (a)
            3'd0: return d ? "R1 divisor low read" : "R11 receive buffer read";
            3'd1: return d ? "R1 divisor high read" : "R2 enable read";
            3'd2: return "R3 ident read";
            3'd5: return "R12 status read";
            3'd6: return "R3 modem status read";
            default: return "R4 control/scratch read";
        endcase
    endfunction

    // one clock cycle: drive, check before the edge, update the model after it
    task automatic cycle(input logic rd, input logic wr, input logic [2:0] a,
                         input logic [7:0] wd, input logic rxv, input logic [7:0] rxd,
                         input logic txr, input string tag);
        logic dlab, loop, wthr, tx_pop, tx_push, lb_ok, lb_ovf, dv_ok, dv_ovf, rx_pop, lsr_rd, last;
        logic [7:0] iir;
        iir        = 8'($urandom);
        host_rd    = rd;
        host_wr    = wr;
        host_addr  = a;
        host_wdata = wd;
        rx_valid   = rxv;
        rx_data    = rxd;
        tx_ready   = txr;
        iir_in     = iir;
        #(PERIOD/2 - 1);
        if (rd) chk((tag != "") ? tag : read_tag(a), {8'h0, host_rdata}, {8'h0, exp_read(a, iir)});
        chk("R6/R9/R12 line_status", {8'h0, line_status}, {8'h0, exp_lsr()});
        chk("R7 tx_valid", {15'h0, tx_valid}, {15'h0, (m_txq.size() != 0)});
        if (m_txq.size() != 0) chk("R7 tx_data order", {8'h0, tx_data}, {8'h0, m_txq[0]});
        chk("R9/R10 rx_ready", {15'h0, rx_ready}, {15'h0, (!m_mcr[4] && m_rxq.size() < DEPTH)});
        chk("R2 irq_enable", {12'h0, irq_enable}, {12'h0, m_ier});
        chk("R1 divisor", divisor, {m_dlh, m_dll});
        chk("R8 thre_event", {15'h0, thre_event}, {15'h0, m_ev});
        @(posedge clk);
        dlab    = m_lcr[7];
        loop    = m_mcr[4];
        wthr    = wr && a == 3'd0 && !dlab;
        tx_pop  = (m_txq.size() != 0) && txr;
        tx_push = wthr && !loop && m_txq.size() < DEPTH;
        lb_ok   = wthr && loop && m_rxq.size() < DEPTH;
        lb_ovf  = wthr && loop && m_rxq.size() >= DEPTH;
        dv_ok   = rxv && !loop && m_rxq.size() < DEPTH;
        dv_ovf  = rxv && !loop && m_rxq.size() >= DEPTH;
        rx_pop  = rd && a == 3'd0 && !dlab && m_rxq.size() != 0;
        lsr_rd  = rd && a == 3'd5;
        last    = tx_pop && m_txq.size() == 1 && !wthr;
        if (wr) begin
            case (a)
                3'd0: if (dlab) m_dll = wd;
                3'd1: if (dlab) m_dlh = wd; else m_ier = wd[3:0];
                3'd3: m_lcr = wd;
                3'd4: m_mcr = wd[4:0];
                3'd7: m_scr = wd;
                default: ;
            endcase
        end
        if (lsr_rd) m_oe = 1'b0;
        if (lb_ovf || dv_ovf) m_oe = 1'b1;
        if (wthr) m_thre = loop;
        else if (last) m_thre = 1'b1;
        m_ev = last;
        if (rx_pop) void'(m_rxq.pop_front());
        if (lb_ok) m_rxq.push_back(wd);
        if (dv_ok) m_rxq.push_back(rxd);
        if (tx_pop) void'(m_txq.pop_front());
        if (tx_push) m_txq.push_back(wd);
        @(negedge clk);
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d, input string tag);
        cycle(1'b0, 1'b1, a, d, 1'b0, 8'h00, 1'b0, tag);
    endtask

    task automatic rd_reg(input logic [2:0] a, input string tag);
        cycle(1'b1, 1'b0, a, 8'h00, 1'b0, 8'h00, 1'b0, tag);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL R7 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'h1c5a_7e01));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 reset values
        for (int a = 0; a < 8; a++) rd_reg(3'(a), "R5 reset read");
        wr_reg(3'd3, 8'h80, "");
        rd_reg(3'd0, "R5 reset divisor low");
        rd_reg(3'd1, "R5 reset divisor high");

        // R1 divisor access under bit 7
        wr_reg(3'd0, 8'h34, "");
        wr_reg(3'd1, 8'h12, "");
        rd_reg(3'd0, "R1 divisor low");
        rd_reg(3'd1, "R1 divisor high");
        wr_reg(3'd3, 8'h5b, "");
        rd_reg(3'd3, "R4 line control all bits");

        // R2 / R4 masking, R3 ignored writes
        wr_reg(3'd1, 8'hff, "");
        rd_reg(3'd1, "R2 enable masked");
        wr_reg(3'd4, 8'hef, "");
        rd_reg(3'd4, "R4 modem control masked");
        wr_reg(3'd2, 8'hff, "");
        wr_reg(3'd5, 8'h00, "");
        wr_reg(3'd6, 8'hff, "");
        rd_reg(3'd5, "R3 status after ignored write");
        rd_reg(3'd6, "R3 modem status zero");
        wr_reg(3'd7, 8'ha5, "");
        rd_reg(3'd7, "R4 scratch");

        // R6 / R13 transmit queue overflow, then drain (R7, R8)
        for (int i = 0; i < DEPTH + 2; i++) wr_reg(3'd0, 8'(8'h40 + i), "");
        rd_reg(3'd5, "R6 status after transmit writes");
        for (int i = 0; i < DEPTH + 4; i++) cycle(1'b0, 1'b0, 3'd0, 8'h00, 1'b0, 8'h00, 1'b1, "");

        // R9 loopback overflow, R12 overrun clear, R11 reads
        wr_reg(3'd4, 8'h10, "");
        for (int i = 0; i < DEPTH + 1; i++) wr_reg(3'd0, 8'(8'h80 + i), "");
        cycle(1'b0, 1'b0, 3'd0, 8'h00, 1'b1, 8'h77, 1'b0, "");
        rd_reg(3'd5, "R12 overrun shown");
        rd_reg(3'd5, "R12 overrun cleared");
        for (int i = 0; i < DEPTH + 1; i++) rd_reg(3'd0, "R11 loopback data");
        wr_reg(3'd4, 8'h00, "");

        // R10 device pushes into a full queue
        for (int i = 0; i < DEPTH + 2; i++) cycle(1'b0, 1'b0, 3'd0, 8'h00, 1'b1, 8'(8'hc0 + i), 1'b0, "");
        rd_reg(3'd5, "R10 overrun from device");
        for (int i = 0; i < DEPTH + 1; i++) rd_reg(3'd0, "R11 device data");

        // constrained random mix
        for (int i = 0; i < 6000; i++) begin
            int op = int'($urandom % 10);
            logic [2:0] a = 3'($urandom);
            logic [7:0] d = 8'($urandom);
            logic txr;
            if (a == 3'd3) d[7] = ($urandom % 8 == 0);
            if (a == 3'd4) d[4] = ($urandom % 4 == 0);
            if (op < 3 && $urandom % 2 == 0) a = 3'd0;
            txr = (i < 3000) ? ($urandom % 5 == 0) : ($urandom % 4 != 0);
            cycle(op < 4, (op >= 4 && op < 8), a, d, ($urandom % 10 < 3), 8'($urandom), txr, "");
        end

        summary();
        $finish;
    end

endmodule